// File: doc/BRIEF.md
# Queue Head Halt and Error Handler

This block is handed the outcome of a single bus transaction on an endpoint served by a queue head (control, bulk or interrupt). It uses that outcome and the current overlay fields to decide what happens next. The transaction can advance the transfer, or it can be retried while the error budget lasts. It can also halt the endpoint. Which one happens depends on whether the endpoint stalled or babbled, and on how many consecutive transaction errors have built up. The outcome arrives as a flag vector on a one-cycle `txnValid` pulse. One cycle later the block presents the updated overlay. It also raises a write-back strobe when the transfer has ended and the overlay has to be copied back to its descriptor.

A halt sets a sticky error-status bit, which software clears by writing a one. The halt does not raise an interrupt straight away. The request is held until the next interrupt-threshold tick and is released only if the enable is set and the status bit is still set. Memory fetch and the packet engine are outside this block.

Top module: `qhHaltUnit`

## Requirements
- R1: A transaction whose result has bit 2 (stall) set halts the endpoint and reports halt cause 1.
- R2: The 2-bit error counter drops by one on every result with bit 0 (transaction error) set and never wraps below 0. A clean transaction reloads it to 3. An error that arrives while the counter is 1 or 0 halts the endpoint with cause 3, and leaves the counter at 0.
- R3: A transaction whose result has bit 1 (babble) set halts the endpoint and reports cause 2, unless a stall is also reported.
- R4: On a halt the new active flag is 0 and the new halted flag is 1. The error bits {stall, babble, transaction error} (positions 2, 1, 0) are ORed with the reported flags.
- R5: On a halt the byte count, page, offset and data toggle are passed through unchanged. Only the counter and the error bits change.
- R6: `writeBack` pulses for one cycle, together with `updValid`, in exactly three cases: a halt, a short packet (result bit 3), or a byte count that reaches 0. An error that does not halt leaves active at 1, freezes the transfer state and gives no write-back.
- R7: A clean transaction subtracts `xferLen` from the byte count, saturating at 0. It adds `xferLen` to the offset, carries into the page modulo 2^PAGE_W, and flips the data toggle.
- R8: `errStatus` is set by a halt and stays set until a `statusClear` pulse. When a set and a clear arrive in the same cycle, the set wins.
- R9: `irq` rises only in the cycle after a `thresholdTick`, and only if `errStatus` and `intEnable` were both 1 at that tick. It drops with `statusClear`, and a clear that comes before the tick means no interrupt.
- R10: When several halt causes arrive together, the cause is priority-encoded (stall, then babble, then error limit). All matching error bits are set, and only one write-back pulse is issued.
- R11: A transaction whose overlay is inactive or already halted is ignored: `updValid` stays 0 and the output fields keep their values.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnValid | input | 1 | Transaction result is valid this cycle |
| resultCode | input | 4 | Flags: 0 xact error, 1 babble, 2 stall, 3 short packet |
| xferLen | input | LEN_W | Bytes moved by the transaction |
| ovlActive | input | 1 | Overlay active flag |
| ovlHalted | input | 1 | Overlay halted flag |
| ovlBytes | input | BYTES_W | Bytes left to transfer |
| ovlPage | input | PAGE_W | Current page index |
| ovlOffset | input | OFFS_W | Current offset within the page |
| ovlToggle | input | 1 | Data toggle |
| ovlErrCnt | input | 2 | Error down-counter |
| ovlErrBits | input | 3 | Error bits {stall, babble, xact} |
| intEnable | input | 1 | Error interrupt enable |
| thresholdTick | input | 1 | Interrupt threshold boundary |
| statusClear | input | 1 | Write-one-to-clear pulse for errStatus |
| updValid | output | 1 | Updated overlay is valid (one cycle) |
| writeBack | output | 1 | Overlay must be written back (one cycle) |
| newActive | output | 1 | Updated active flag |
| newHalted | output | 1 | Updated halted flag |
| newBytes | output | BYTES_W | Updated byte count |
| newPage | output | PAGE_W | Updated page |
| newOffset | output | OFFS_W | Updated offset |
| newToggle | output | 1 | Updated data toggle |
| newErrCnt | output | 2 | Updated error counter |
| newErrBits | output | 3 | Updated error bits |
| haltCause | output | 2 | 0 none, 1 stall, 2 babble, 3 error limit |
| errStatus | output | 1 | Sticky error-interrupt status |
| irq | output | 1 | Error interrupt line |

## Verification
The bench builds the block with BYTES_W=8, OFFS_W=4, PAGE_W=2 and LEN_W=4. With these widths an offset rollover into the page, and a page wrap back to 0, each take a single transaction. A byte count can also be run down to 0 with a short length. The counter width stays fixed at 2 bits, so the full three-error sequence, including the no-wrap case at 0, runs the same way as with the default widths.

// File: rtl/qhh_pkg.sv
package qhh_pkg;

  localparam int RES_XACT   = 0;
  localparam int RES_BABBLE = 1;
  localparam int RES_STALL  = 2;
  localparam int RES_SHORT  = 3;
  localparam logic [1:0] ERR_RELOAD = 2'd3;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_STALL  = 2'd1,
    CAUSE_BABBLE = 2'd2,
    CAUSE_ERRLIM = 2'd3
  } haltCause_e;

  typedef struct packed {
    logic       load;
    logic       halt;
    logic       advance;
    logic       decErr;
    logic       isShort;
    logic [2:0] setBits;
    haltCause_e cause;
  } ctlStrobe_t;

endpackage

// File: rtl/qhhCtrl.sv
module qhhCtrl
  import qhh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txnValid,
  input  logic [3:0] resultCode,
  input  logic       ovlActive,
  input  logic       ovlHalted,
  input  logic [1:0] ovlErrCnt,
  input  logic       intEnable,
  input  logic       thresholdTick,
  input  logic       statusClear,
  output ctlStrobe_t ctl,
  output logic       errStatus,
  output logic       irq
);

  logic accept;
  logic isErr;
  logic errLimit;
  logic haltNow;
  haltCause_e cause;

  always_comb begin
    accept   = txnValid && ovlActive && !ovlHalted;
    isErr    = resultCode[RES_XACT];
    errLimit = isErr && (ovlErrCnt <= 2'd1);
    haltNow  = resultCode[RES_STALL] || resultCode[RES_BABBLE] || errLimit;
    if (resultCode[RES_STALL])       cause = CAUSE_STALL;
    else if (resultCode[RES_BABBLE]) cause = CAUSE_BABBLE;
    else if (errLimit)               cause = CAUSE_ERRLIM;
    else                             cause = CAUSE_NONE;

    ctl.load    = accept;
    ctl.halt    = haltNow;
    ctl.advance = !haltNow && !isErr;
    ctl.decErr  = isErr;
    ctl.isShort = resultCode[RES_SHORT];
    ctl.setBits = {resultCode[RES_STALL], resultCode[RES_BABBLE], resultCode[RES_XACT]};
    ctl.cause   = cause;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errStatus <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (accept && haltNow)  errStatus <= 1'b1;
      else if (statusClear)   errStatus <= 1'b0;

      if (statusClear)        irq <= 1'b0;
      else if (thresholdTick) irq <= errStatus && intEnable;
    end
  end

endmodule

// File: rtl/qhhDatapath.sv
module qhhDatapath
  import qhh_pkg::*;
#(
  parameter int BYTES_W = 15,
  parameter int OFFS_W  = 12,
  parameter int PAGE_W  = 3,
  parameter int LEN_W   = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [LEN_W-1:0]   xferLen,
  input  logic               ovlHalted,
  input  logic [BYTES_W-1:0] ovlBytes,
  input  logic [PAGE_W-1:0]  ovlPage,
  input  logic [OFFS_W-1:0]  ovlOffset,
  input  logic               ovlToggle,
  input  logic [1:0]         ovlErrCnt,
  input  logic [2:0]         ovlErrBits,
  output logic               updValid,
  output logic               writeBack,
  output logic               newActive,
  output logic               newHalted,
  output logic [BYTES_W-1:0] newBytes,
  output logic [PAGE_W-1:0]  newPage,
  output logic [OFFS_W-1:0]  newOffset,
  output logic               newToggle,
  output logic [1:0]         newErrCnt,
  output logic [2:0]         newErrBits,
  output logic [1:0]         haltCause
);

  localparam int SUM_W = OFFS_W + 1;

  logic [BYTES_W-1:0] lenBytes;
  logic [BYTES_W-1:0] bytesAdv;
  logic [SUM_W-1:0]   offsSum;
  logic [PAGE_W-1:0]  pageAdv;
  logic [1:0]         cntNext;
  logic               xferEnd;

  always_comb begin
    lenBytes = BYTES_W'(xferLen);
    bytesAdv = (lenBytes >= ovlBytes) ? '0 : (ovlBytes - lenBytes);
    offsSum  = {1'b0, ovlOffset} + SUM_W'(xferLen);
    pageAdv  = ovlPage + PAGE_W'(offsSum[OFFS_W]);

    if (ctl.advance)                         cntNext = ERR_RELOAD;
    else if (ctl.decErr && ovlErrCnt != 2'd0) cntNext = ovlErrCnt - 2'd1;
    else                                     cntNext = ovlErrCnt;

    xferEnd = ctl.halt || (ctl.advance && (ctl.isShort || bytesAdv == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updValid   <= 1'b0;
      writeBack  <= 1'b0;
      newActive  <= 1'b0;
      newHalted  <= 1'b0;
      newBytes   <= '0;
      newPage    <= '0;
      newOffset  <= '0;
      newToggle  <= 1'b0;
      newErrCnt  <= 2'd0;
      newErrBits <= 3'd0;
      haltCause  <= 2'd0;
    end else if (ctl.load) begin
      updValid   <= 1'b1;
      writeBack  <= xferEnd;
      newActive  <= !xferEnd;
      newHalted  <= ctl.halt || ovlHalted;
      newErrCnt  <= cntNext;
      newErrBits <= ovlErrBits | ctl.setBits;
      haltCause  <= ctl.cause;
      if (ctl.advance) begin
        newBytes  <= bytesAdv;
        newPage   <= pageAdv;
        newOffset <= offsSum[OFFS_W-1:0];
        newToggle <= !ovlToggle;
      end else begin
        newBytes  <= ovlBytes;
        newPage   <= ovlPage;
        newOffset <= ovlOffset;
        newToggle <= ovlToggle;
      end
    end else begin
      updValid  <= 1'b0;
      writeBack <= 1'b0;
    end
  end

endmodule

// File: rtl/qhHaltUnit.sv
module qhHaltUnit
  import qhh_pkg::*;
#(
  parameter int BYTES_W = 15,
  parameter int OFFS_W  = 12,
  parameter int PAGE_W  = 3,
  parameter int LEN_W   = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txnValid,
  input  logic [3:0]         resultCode,
  input  logic [LEN_W-1:0]   xferLen,
  input  logic               ovlActive,
  input  logic               ovlHalted,
  input  logic [BYTES_W-1:0] ovlBytes,
  input  logic [PAGE_W-1:0]  ovlPage,
  input  logic [OFFS_W-1:0]  ovlOffset,
  input  logic               ovlToggle,
  input  logic [1:0]         ovlErrCnt,
  input  logic [2:0]         ovlErrBits,
  input  logic               intEnable,
  input  logic               thresholdTick,
  input  logic               statusClear,
  output logic               updValid,
  output logic               writeBack,
  output logic               newActive,
  output logic               newHalted,
  output logic [BYTES_W-1:0] newBytes,
  output logic [PAGE_W-1:0]  newPage,
  output logic [OFFS_W-1:0]  newOffset,
  output logic               newToggle,
  output logic [1:0]         newErrCnt,
  output logic [2:0]         newErrBits,
  output logic [1:0]         haltCause,
  output logic               errStatus,
  output logic               irq
);

  ctlStrobe_t ctl;

  qhhCtrl ctrlI (
    .clk(clk), .rstN(rstN), .txnValid(txnValid), .resultCode(resultCode),
    .ovlActive(ovlActive), .ovlHalted(ovlHalted), .ovlErrCnt(ovlErrCnt),
    .intEnable(intEnable), .thresholdTick(thresholdTick),
    .statusClear(statusClear), .ctl(ctl), .errStatus(errStatus), .irq(irq)
  );

  qhhDatapath #(
    .BYTES_W(BYTES_W), .OFFS_W(OFFS_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)
  ) dpI (
    .clk(clk), .rstN(rstN), .ctl(ctl), .xferLen(xferLen),
    .ovlHalted(ovlHalted), .ovlBytes(ovlBytes), .ovlPage(ovlPage),
    .ovlOffset(ovlOffset), .ovlToggle(ovlToggle), .ovlErrCnt(ovlErrCnt),
    .ovlErrBits(ovlErrBits), .updValid(updValid), .writeBack(writeBack),
    .newActive(newActive), .newHalted(newHalted), .newBytes(newBytes),
    .newPage(newPage), .newOffset(newOffset), .newToggle(newToggle),
    .newErrCnt(newErrCnt), .newErrBits(newErrBits), .haltCause(haltCause)
  );

endmodule

// File: rtl/qhhChecker.sv
module qhhChecker #(
  parameter int BYTES_W = 15,
  parameter int OFFS_W  = 12,
  parameter int PAGE_W  = 3,
  parameter int LEN_W   = 11
) (
  input logic               clk,
  input logic               rstN,
  input logic               txnValid,
  input logic [3:0]         resultCode,
  input logic [LEN_W-1:0]   xferLen,
  input logic               ovlActive,
  input logic               ovlHalted,
  input logic [BYTES_W-1:0] ovlBytes,
  input logic [PAGE_W-1:0]  ovlPage,
  input logic [OFFS_W-1:0]  ovlOffset,
  input logic               ovlToggle,
  input logic [1:0]         ovlErrCnt,
  input logic [2:0]         ovlErrBits,
  input logic               intEnable,
  input logic               thresholdTick,
  input logic               statusClear,
  input logic               updValid,
  input logic               writeBack,
  input logic               newActive,
  input logic               newHalted,
  input logic [BYTES_W-1:0] newBytes,
  input logic [PAGE_W-1:0]  newPage,
  input logic [OFFS_W-1:0]  newOffset,
  input logic               newToggle,
  input logic [1:0]         newErrCnt,
  input logic [2:0]         newErrBits,
  input logic [1:0]         haltCause,
  input logic               errStatus,
  input logic               irq
);

  a_r4_halt_flags: assert property (@(posedge clk) disable iff (!rstN)
    updValid && newHalted |-> !newActive && writeBack);

  a_r5_frozen_on_halt: assert property (@(posedge clk) disable iff (!rstN)
    updValid && newHalted |-> newBytes == $past(ovlBytes) && newPage == $past(ovlPage)
      && newOffset == $past(ovlOffset) && newToggle == $past(ovlToggle));

  a_r6_wb_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    writeBack |-> updValid);

  a_r6_end_needs_wb: assert property (@(posedge clk) disable iff (!rstN)
    updValid && !newActive |-> writeBack);

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errStatus && !statusClear |=> errStatus);

  a_r8_status_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errStatus) |-> writeBack && newHalted);

  a_r9_irq_at_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(thresholdTick) && $past(errStatus) && $past(intEnable));

  a_r10_cause_on_halt: assert property (@(posedge clk) disable iff (!rstN)
    updValid && newHalted |-> haltCause != 2'd0);

  a_r11_accept_only_live: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> $past(txnValid) && $past(ovlActive) && !$past(ovlHalted));

  a_r2_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    updValid && $past(resultCode[0]) && $past(ovlErrCnt) == 2'd0 |-> newErrCnt == 2'd0);

endmodule

bind qhHaltUnit qhhChecker #(
  .BYTES_W(BYTES_W), .OFFS_W(OFFS_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)
) chkI (.*);

// File: tb/qhHaltUnit_test.sv
`timescale 1ns/1ps
module qhHaltUnit_test;

  localparam int BYTES_W = 8;
  localparam int OFFS_W  = 4;
  localparam int PAGE_W  = 2;
  localparam int LEN_W   = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               txnValid = 1'b0;
  logic [3:0]         resultCode = '0;
  logic [LEN_W-1:0]   xferLen = '0;
  logic               ovlActive = 1'b0;
  logic               ovlHalted = 1'b0;
  logic [BYTES_W-1:0] ovlBytes = '0;
  logic [PAGE_W-1:0]  ovlPage = '0;
  logic [OFFS_W-1:0]  ovlOffset = '0;
  logic               ovlToggle = 1'b0;
  logic [1:0]         ovlErrCnt = '0;
  logic [2:0]         ovlErrBits = '0;
  logic               intEnable = 1'b0;
  logic               thresholdTick = 1'b0;
  logic               statusClear = 1'b0;
  logic               updValid, writeBack, newActive, newHalted, newToggle;
  logic [BYTES_W-1:0] newBytes;
  logic [PAGE_W-1:0]  newPage;
  logic [OFFS_W-1:0]  newOffset;
  logic [1:0]         newErrCnt, haltCause;
  logic [2:0]         newErrBits;
  logic               errStatus, irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  qhHaltUnit #(.BYTES_W(BYTES_W), .OFFS_W(OFFS_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rstN(rstN), .txnValid(txnValid), .resultCode(resultCode),
    .xferLen(xferLen), .ovlActive(ovlActive), .ovlHalted(ovlHalted),
    .ovlBytes(ovlBytes), .ovlPage(ovlPage), .ovlOffset(ovlOffset),
    .ovlToggle(ovlToggle), .ovlErrCnt(ovlErrCnt), .ovlErrBits(ovlErrBits),
    .intEnable(intEnable), .thresholdTick(thresholdTick), .statusClear(statusClear),
    .updValid(updValid), .writeBack(writeBack), .newActive(newActive),
    .newHalted(newHalted), .newBytes(newBytes), .newPage(newPage),
    .newOffset(newOffset), .newToggle(newToggle), .newErrCnt(newErrCnt),
    .newErrBits(newErrBits), .haltCause(haltCause), .errStatus(errStatus), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One transaction: drive after a falling edge, result is sampled one cycle later.
  task automatic sendTxn(input bit act, input bit hlt, input int bytes, input int page,
                         input int offs, input bit tog, input int cnt, input int bits,
                         input int res, input int len);
    @(negedge clk);
    txnValid = 1'b1; ovlActive = act; ovlHalted = hlt; ovlBytes = BYTES_W'(bytes);
    ovlPage = PAGE_W'(page); ovlOffset = OFFS_W'(offs); ovlToggle = tog;
    ovlErrCnt = 2'(cnt); ovlErrBits = 3'(bits); resultCode = 4'(res); xferLen = LEN_W'(len);
    @(negedge clk);
    txnValid = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); statusClear = 1'b1;
    @(negedge clk); statusClear = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); thresholdTick = 1'b1;
    @(negedge clk); thresholdTick = 1'b0;
  endtask

  task automatic testReset();
    chk("R12 updValid", updValid, 0);
    chk("R12 writeBack", writeBack, 0);
    chk("R12 errStatus", errStatus, 0);
    chk("R12 irq", irq, 0);
    chk("R12 newErrCnt", newErrCnt, 0);
  endtask

  task automatic testAdvance();
    sendTxn(1, 0, 40, 1, 14, 0, 2, 0, 0, 3);
    chk("R7 updValid", updValid, 1);
    chk("R7 bytes", newBytes, 37);
    chk("R7 offset carry", newOffset, 1);
    chk("R7 page carry", newPage, 2);
    chk("R7 toggle", newToggle, 1);
    chk("R2 reload", newErrCnt, 3);
    chk("R6 no wb mid transfer", writeBack, 0);
    chk("R6 stays active", newActive, 1);
    sendTxn(1, 0, 40, 3, 15, 1, 3, 0, 0, 1);
    chk("R7 page wrap", newPage, 0);
    chk("R7 offset wrap", newOffset, 0);
    chk("R7 toggle back", newToggle, 0);
  endtask

  task automatic testEnds();
    sendTxn(1, 0, 40, 0, 0, 0, 3, 0, 8, 2);
    chk("R6 short wb", writeBack, 1);
    chk("R6 short inactive", newActive, 0);
    chk("R6 short bytes", newBytes, 38);
    chk("R6 short not halted", newHalted, 0);
    sendTxn(1, 0, 5, 0, 0, 0, 3, 0, 0, 8);
    chk("R7 bytes saturate", newBytes, 0);
    chk("R6 zero bytes wb", writeBack, 1);
    @(negedge clk);
    chk("R6 wb one cycle", writeBack, 0);
  endtask

  task automatic testErrors();
    sendTxn(1, 0, 20, 1, 5, 1, 3, 0, 1, 4);
    chk("R2 3 to 2", newErrCnt, 2);
    chk("R6 retry active", newActive, 1);
    chk("R6 retry no wb", writeBack, 0);
    chk("R6 retry bytes frozen", newBytes, 20);
    chk("R6 retry toggle frozen", newToggle, 1);
    sendTxn(1, 0, 20, 1, 5, 1, 2, 1, 1, 4);
    chk("R2 2 to 1", newErrCnt, 1);
    chk("R2 not halted yet", newHalted, 0);
    sendTxn(1, 0, 20, 1, 5, 1, 1, 1, 1, 4);
    chk("R2 third error halts", newHalted, 1);
    chk("R2 count 0", newErrCnt, 0);
    chk("R2 cause", haltCause, 3);
    chk("R4 active cleared", newActive, 0);
    chk("R5 offset frozen", newOffset, 5);
    chk("R8 status set", errStatus, 1);
    sendTxn(1, 0, 20, 1, 5, 1, 0, 0, 1, 4);
    chk("R2 no wrap", newErrCnt, 0);
    chk("R2 halt at zero", newHalted, 1);
    pulseClear();
    chk("R8 cleared", errStatus, 0);
  endtask

  task automatic testStallBabble();
    sendTxn(1, 0, 30, 2, 7, 1, 2, 0, 4, 5);
    chk("R1 halted", newHalted, 1);
    chk("R1 cause", haltCause, 1);
    chk("R5 bytes frozen", newBytes, 30);
    chk("R5 page frozen", newPage, 2);
    chk("R5 toggle frozen", newToggle, 1);
    chk("R5 cnt unchanged", newErrCnt, 2);
    chk("R4 stall bit", newErrBits, 4);
    sendTxn(1, 0, 30, 2, 7, 0, 3, 0, 2, 5);
    chk("R3 cause", haltCause, 2);
    chk("R3 babble bit", newErrBits, 2);
    chk("R3 wb", writeBack, 1);
    sendTxn(1, 0, 30, 2, 7, 0, 1, 0, 7, 5);
    chk("R10 cause priority", haltCause, 1);
    chk("R10 all bits", newErrBits, 7);
    chk("R10 wb", writeBack, 1);
    @(negedge clk);
    chk("R10 single strobe", writeBack, 0);
    pulseClear();
  endtask

  task automatic testIgnored();
    sendTxn(1, 0, 50, 0, 0, 0, 3, 0, 0, 2);
    chk("R7 baseline bytes", newBytes, 48);
    sendTxn(0, 0, 10, 0, 0, 0, 3, 0, 4, 2);
    chk("R11 inactive no valid", updValid, 0);
    chk("R11 bytes kept", newBytes, 48);
    chk("R11 no status", errStatus, 0);
    sendTxn(1, 1, 10, 0, 0, 0, 3, 0, 0, 2);
    chk("R11 halted no valid", updValid, 0);
    chk("R11 bytes kept again", newBytes, 48);
  endtask

  task automatic testIrq();
    intEnable = 1'b1;
    sendTxn(1, 0, 9, 0, 0, 0, 3, 0, 4, 1);
    chk("R9 status set", errStatus, 1);
    chk("R9 no irq before tick", irq, 0);
    repeat (3) @(negedge clk);
    chk("R9 still deferred", irq, 0);
    pulseTick();
    chk("R9 irq after tick", irq, 1);
    pulseClear();
    chk("R9 irq dropped", irq, 0);
    chk("R8 status clear", errStatus, 0);
    sendTxn(1, 0, 9, 0, 0, 0, 3, 0, 4, 1);
    pulseClear();
    pulseTick();
    chk("R9 clear before tick", irq, 0);
    intEnable = 1'b0;
    sendTxn(1, 0, 9, 0, 0, 0, 3, 0, 2, 1);
    pulseTick();
    chk("R9 disabled no irq", irq, 0);
    chk("R9 status still set", errStatus, 1);
    pulseClear();
    @(negedge clk);
    txnValid = 1'b1; ovlActive = 1'b1; ovlHalted = 1'b0; resultCode = 4'd4; statusClear = 1'b1;
    @(negedge clk);
    txnValid = 1'b0; statusClear = 1'b0;
    chk("R8 set wins", errStatus, 1);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAdvance();
    testEnds();
    testErrors();
    testStallBabble();
    testIgnored();
    testIrq();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule